// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address-Wake Filtering

The block is a full-duplex asynchronous serial transceiver. One frame format and one bit rate serve both directions. The frame format covers 8 or 9 data bits, an optional even or odd parity bit, and one or two stop bits. A 16-bit divider sets the bit rate. Outgoing words wait in a transmit queue and received words wait in a receive queue. Each queue is `FIFO_DEPTH` deep, or can be cut down at run time to a single holding entry. Every received word carries its own parity-error and framing-error flags. A one-cycle pulse reports a word that was lost because the receive queue was full.

In 9-bit mode the top data bit marks an address word. With address-wake enabled, the receiver stores no data words until an address word equal to the node address arrives. It then stores data words until a different address word puts it back to sleep. For test, a loopback switch routes the transmit stream straight into the receiver.

The configuration is applied as static inputs. Words are written with a single-cycle write strobe. The head of the receive queue is always visible at the outputs and is removed with a single-cycle read strobe.

Top module: `uart_mp`

## Requirements
- R1: The transmitter holds each bit on the line for exactly 16*(cfg_div+1) clock cycles.
- R2: A frame on the line is built as follows:
  - The idle line is 1.
  - A start bit of 0 comes first.
  - The data bits follow, least significant first: 8 of them, or 9 when cfg_nine=1.
  - A parity bit follows when cfg_par_en=1.
  - The frame ends with one stop bit of 1, or two when cfg_two_stop=1.
  - In 8-bit mode, tx_data[8] is not sent and rx_data[8] reads 0.
- R3: Parity is handled as follows:
  - The parity bit is the XOR of the sent data bits, inverted when cfg_par_odd=1.
  - A received parity bit that disagrees with this value sets rx_perr with the stored word.
  - The data of that word is still stored.
- R4: The receiver samples each bit 16 times and takes a majority vote of samples 7, 8 and 9. A start bit that votes 1 is discarded as noise and stores nothing.
- R5: If the first stop bit votes 0, the word is stored with rx_ferr=1. The receiver checks only the first stop bit.
- R6: Queue depth and status:
  - With cfg_fifo_en=1, each queue holds FIFO_DEPTH words.
  - With cfg_fifo_en=0, each queue holds one word.
  - tx_full is 1 when the transmit queue is full.
  - rx_empty is 1 when the receive queue is empty.
- R7: If a word that would be stored completes while the receive queue is full, the following happens:
  - The word is dropped.
  - rx_ovr pulses for one cycle.
  - The queued words are kept unchanged.
- R8: Address-wake filtering applies when cfg_addr_wake=1 and cfg_nine=1:
  - A word with bit 8 = 1 is an address word.
  - A data word (bit 8 = 0) is discarded while the receiver is asleep.
  - An address word whose bits 7:0 equal cfg_node wakes the receiver and is itself stored.
  - Any other address word puts the receiver to sleep and is discarded.
- R9: With cfg_loop=1, the receiver takes the internal transmit stream, the external rxd input is ignored, and txd is held at 1.
- R10: After reset, the outputs are in this state:
  - txd is 1.
  - rx_empty is 1.
  - tx_full is 0.
  - rx_ovr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Divider reload; oversample tick every cfg_div+1 cycles |
| cfg_nine | input | 1 | 9 data bits when 1, else 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits on transmit |
| cfg_fifo_en | input | 1 | Full-depth queues when 1, single entry when 0 |
| cfg_loop | input | 1 | Internal loopback |
| cfg_addr_wake | input | 1 | Address-wake filtering (9-bit mode) |
| cfg_node | input | 8 | Node address |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 9 | Word to send |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Remove head of receive queue |
| rx_data | output | 9 | Head word of receive queue |
| rx_perr | output | 1 | Parity error of head word |
| rx_ferr | output | 1 | Framing error of head word |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovr | output | 1 | One-cycle pulse: word dropped on full queue |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench builds the block with FIFO_DEPTH=4 and the default DIV_W=16. With a depth of 4, a queue fills after only four frames, so the overrun path and the drop of the fifth word are reached in a short run. Divider values from 0 to 2 give bit times of 16 to 48 cycles. These short bit times allow many randomly configured loopback frames, exact bit-length measurement on txd, and externally driven frames with corrupted parity, corrupted stop bits and short start glitches.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
    localparam int OSR    = 16;
    localparam int WORD_W = 9;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} line_state_e;

    function automatic logic calc_parity(logic [WORD_W-1:0] d, logic nine, logic odd);
        logic p;
        p = ^d[7:0];
        if (nine) p = p ^ d[8];
        return p ^ odd;
    endfunction

    function automatic logic vote3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uart_mp_baud.sv
module uart_mp_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= div;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/uart_mp_fifo.sv
module uart_mp_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    // R7
    fifo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
    import uart_mp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              avail,
    input  logic [WORD_W-1:0] din,
    output logic              pop,
    output logic              line
);
    line_state_e       state;
    logic [3:0]        tcnt;
    logic [3:0]        bitn;
    logic [WORD_W-1:0] sh;
    logic              par_b;
    logic              stop2;
    logic [3:0]        last_bit;

    assign last_bit = cfg.nine ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            line  <= 1'b1;
            pop   <= 1'b0;
            tcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
            par_b <= 1'b0;
            stop2 <= 1'b0;
        end else begin
            pop <= 1'b0;
            if (state == ST_IDLE) begin
                line <= 1'b1;
                if (tick && avail) begin
                    pop   <= 1'b1;
                    sh    <= din;
                    par_b <= calc_parity(din, cfg.nine, cfg.par_odd);
                    tcnt  <= '0;
                    line  <= 1'b0;
                    state <= ST_START;
                end
            end else if (tick) begin
                tcnt <= tcnt + 4'd1;
                if (tcnt == 4'(OSR - 1)) begin
                    case (state)
                        ST_START: begin
                            bitn  <= '0;
                            line  <= sh[0];
                            state <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (bitn == last_bit) begin
                                if (cfg.par_en) begin
                                    line  <= par_b;
                                    state <= ST_PAR;
                                end else begin
                                    line  <= 1'b1;
                                    stop2 <= cfg.two_stop;
                                    state <= ST_STOP;
                                end
                            end else begin
                                bitn <= bitn + 4'd1;
                                sh   <= sh >> 1;
                                line <= sh[1];
                            end
                        end
                        ST_PAR: begin
                            line  <= 1'b1;
                            stop2 <= cfg.two_stop;
                            state <= ST_STOP;
                        end
                        default: begin
                            line <= 1'b1;
                            if (stop2) stop2 <= 1'b0;
                            else       state <= ST_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START) |-> !line);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
    import uart_mp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rx_in,
    output logic       done,
    output rx_word_t   word
);
    line_state_e       state;
    logic [3:0]        tcnt;
    logic [3:0]        bitn;
    logic              s7, s8, vote;
    logic [WORD_W-1:0] sh;
    logic              perr_r;
    logic [3:0]        last_bit;

    assign last_bit = cfg.nine ? 4'd8 : 4'd7;
    assign vote     = vote3(s7, s8, rx_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            bitn   <= '0;
            s7     <= 1'b1;
            s8     <= 1'b1;
            sh     <= '0;
            perr_r <= 1'b0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (tick && !rx_in) begin
                    tcnt   <= 4'd1;
                    sh     <= '0;
                    perr_r <= 1'b0;
                    state  <= ST_START;
                end
            end else if (tick) begin
                tcnt <= tcnt + 4'd1;
                if (tcnt == 4'd7) s7 <= rx_in;
                if (tcnt == 4'd8) s8 <= rx_in;
                if (tcnt == 4'd9) begin
                    case (state)
                        ST_START: if (vote) state <= ST_IDLE;
                        ST_DATA:  sh[bitn] <= vote;
                        ST_PAR:   perr_r <= vote ^ calc_parity(sh, cfg.nine, cfg.par_odd);
                        default: begin
                            done       <= 1'b1;
                            word.data  <= sh;
                            word.perr  <= cfg.par_en & perr_r;
                            word.ferr  <= !vote;
                            state      <= ST_IDLE;
                        end
                    endcase
                end
                if (tcnt == 4'(OSR - 1)) begin
                    case (state)
                        ST_START: begin
                            bitn  <= '0;
                            state <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (bitn == last_bit) state <= cfg.par_en ? ST_PAR : ST_STOP;
                            else                  bitn  <= bitn + 4'd1;
                        end
                        ST_PAR:  state <= ST_STOP;
                        default: state <= state;
                    endcase
                end
            end
        end
    end

    // R5
    rx_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4
    rx_start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_IDLE && state == ST_START) |-> ($past(tick) && !$past(rx_in)));
endmodule

// File: rtl/uart_mp.sv
module uart_mp
    import uart_mp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_nine,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             cfg_fifo_en,
    input  logic             cfg_loop,
    input  logic             cfg_addr_wake,
    input  logic [7:0]       cfg_node,
    input  logic             tx_wr,
    input  logic [8:0]       tx_data,
    output logic             tx_full,
    input  logic             rx_rd,
    output logic [8:0]       rx_data,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_empty,
    output logic             rx_ovr,
    input  logic             rxd,
    output logic             txd
);
    localparam int RXW = $bits(rx_word_t);

    frame_cfg_t        fcfg;
    logic              tick;
    logic              tx_empty, tx_pop, tx_line;
    logic [WORD_W-1:0] tx_head;
    logic [1:0]        sync;
    logic              rx_src;
    logic              rx_done;
    rx_word_t          rx_word, rx_head;
    logic [RXW-1:0]    rx_head_bits;
    logic              rx_full;
    logic              awake, filt_on, is_addr, match, keep;

    assign fcfg = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    uart_mp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(cfg_div), .tick(tick));

    uart_mp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .single(!cfg_fifo_en),
        .push(tx_wr), .din(tx_data), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full));

    uart_mp_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(fcfg),
        .avail(!tx_empty), .din(tx_head), .pop(tx_pop), .line(tx_line));

    assign txd    = cfg_loop | tx_line;
    assign rx_src = cfg_loop ? tx_line : rxd;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rx_src};
    end

    uart_mp_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(fcfg),
        .rx_in(sync[1]), .done(rx_done), .word(rx_word));

    assign filt_on = cfg_addr_wake & cfg_nine;
    assign is_addr = rx_word.data[8];
    assign match   = (rx_word.data[7:0] == cfg_node);
    assign keep    = !filt_on || (is_addr ? match : awake);

    always_ff @(posedge clk) begin
        if (rst || !filt_on)         awake <= 1'b0;
        else if (rx_done && is_addr) awake <= match;
    end

    uart_mp_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .single(!cfg_fifo_en),
        .push(rx_done && keep), .din(rx_word), .pop(rx_rd),
        .dout(rx_head_bits), .empty(rx_empty), .full(rx_full));

    assign rx_head = rx_word_t'(rx_head_bits);
    assign rx_data = rx_head.data;
    assign rx_perr = rx_head.perr;
    assign rx_ferr = rx_head.ferr;
    assign rx_ovr  = rx_done && keep && rx_full;

    // R7
    ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && !rx_rd) |=> !rx_empty);
    // R8
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && filt_on && !is_addr && !awake && !rx_rd) |=> $stable(rx_empty));
endmodule

// File: tb/tb_uart_mp.sv
module tb_uart_mp;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_div = 16'd1;
    logic        cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
    logic        cfg_fifo_en = 1, cfg_loop = 0, cfg_addr_wake = 0;
    logic [7:0]  cfg_node = 8'h00;
    logic        tx_wr = 0, rx_rd = 0, rxd = 1;
    logic [8:0]  tx_data = '0;
    logic        tx_full, rx_perr, rx_ferr, rx_empty, rx_ovr, txd;
    logic [8:0]  rx_data;

    int n_checks = 0, n_fail = 0, ovr_cnt = 0, loop_low = 0;

    always #4 clk = ~clk;

    uart_mp #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_nine(cfg_nine),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_fifo_en(cfg_fifo_en), .cfg_loop(cfg_loop), .cfg_addr_wake(cfg_addr_wake),
        .cfg_node(cfg_node), .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_empty(rx_empty), .rx_ovr(rx_ovr), .rxd(rxd), .txd(txd));

    always @(negedge clk) begin
        if (!rst && rx_ovr) ovr_cnt++;
        if (!rst && cfg_loop && !txd) loop_low++;
    end

    function automatic logic ref_par(logic [8:0] d, logic nine, logic odd);
        return (^d[7:0]) ^ (nine & d[8]) ^ odd;
    endfunction

    function automatic int bit_clks();
        return 16 * (int'(cfg_div) + 1);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(logic [8:0] w);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_wr = 1'b1;
        tx_data = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx(output logic [8:0] d, output logic pe, output logic fe);
        d = rx_data; pe = rx_perr; fe = rx_ferr;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic expect_word(string req, logic [8:0] d, logic pe, logic fe);
        logic [8:0] ad; logic ap, af;
        check(!rx_empty, req, "word present", int'(rx_empty), 0);
        if (!rx_empty) begin
            pop_rx(ad, ap, af);
            check(ad == d, req, "data", int'(ad), int'(d));
            check(ap == pe, req, "perr", int'(ap), int'(pe));
            check(af == fe, req, "ferr", int'(af), int'(fe));
        end
    endtask

    task automatic drive_frame(logic [8:0] d, logic badpar, logic stopv);
        int bc;
        logic p;
        bc = bit_clks();
        p  = ref_par(d, cfg_nine, cfg_par_odd) ^ badpar;
        rxd = 1'b0; wait_clks(bc);
        for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin
            rxd = d[i]; wait_clks(bc);
        end
        if (cfg_par_en) begin rxd = p; wait_clks(bc); end
        rxd = stopv; wait_clks(bc);
        rxd = 1'b1; wait_clks(2 * bc);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [8:0] words[$];
        logic [8:0] w;
        int n, bc, lowc;
        logic smp;
        void'($urandom(32'd20240611));

        wait_clks(5);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(txd == 1'b1, "R10", "txd", int'(txd), 1);
        check(rx_empty == 1'b1, "R10", "rx_empty", int'(rx_empty), 1);
        check(tx_full == 1'b0, "R10", "tx_full", int'(tx_full), 0);
        check(rx_ovr == 1'b0, "R10", "rx_ovr", int'(rx_ovr), 0);

        // R1 R2 R3: decode txd with odd parity, two stop bits, 8-bit
        cfg_div = 16'd2; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1; cfg_nine = 0;
        bc = bit_clks();
        fork
            push_tx(9'h1A5);
            begin
                @(negedge clk);
                while (txd) @(negedge clk);
                lowc = 0;
                while (!txd) begin lowc++; @(negedge clk); end
                check(lowc == bc, "R1", "start bit length", lowc, bc);
                wait_clks(bc / 2);
                for (int i = 0; i < 8; i++) begin
                    smp = txd;
                    check(smp == w_bit(9'h0A5, i), "R2", "data bit", int'(smp), int'(w_bit(9'h0A5, i)));
                    wait_clks(bc);
                end
                smp = txd;
                check(smp == ref_par(9'h0A5, 1'b0, 1'b1), "R3", "parity bit", int'(smp), 1);
                wait_clks(bc);
                check(txd == 1'b1, "R2", "stop bit 1", int'(txd), 1);
                wait_clks(bc);
                check(txd == 1'b1, "R2", "stop bit 2", int'(txd), 1);
            end
        join
        wait_clks(2 * bc);

        // R9 R2 R3 R6: random loopback, rxd held low to show it is ignored
        cfg_loop = 1; rxd = 1'b0;
        for (int r = 0; r < 24; r++) begin
            cfg_div = 16'($urandom_range(0, 2));
            cfg_nine = 1'($urandom); cfg_par_en = 1'($urandom);
            cfg_par_odd = 1'($urandom); cfg_two_stop = 1'($urandom);
            bc = bit_clks();
            n = $urandom_range(1, DEPTH);
            words.delete();
            for (int k = 0; k < n; k++) begin
                w = 9'($urandom);
                words.push_back(cfg_nine ? w : {1'b0, w[7:0]});
                push_tx(w);
            end
            wait_clks((n + 1) * 13 * bc);
            foreach (words[k]) expect_word("R9", words[k], 1'b0, 1'b0);
            check(rx_empty == 1'b1, "R6", "drained", int'(rx_empty), 1);
        end
        rxd = 1'b1;
        check(loop_low == 0, "R9", "txd low cycles in loopback", loop_low, 0);

        // R7: overrun with full-depth queue
        cfg_div = 16'd0; cfg_nine = 0; cfg_par_en = 0; cfg_two_stop = 0;
        bc = bit_clks();
        ovr_cnt = 0;
        push_tx(9'h011);
        check(tx_full == 1'b0, "R6", "tx_full after one word, deep", int'(tx_full), 0);
        for (int k = 1; k < DEPTH + 1; k++) push_tx(9'(8'h11 * (k + 1)));
        wait_clks((DEPTH + 3) * 11 * bc);
        check(ovr_cnt == 1, "R7", "overrun pulses", ovr_cnt, 1);
        for (int k = 0; k < DEPTH; k++) expect_word("R7", 9'(8'h11 * (k + 1)), 1'b0, 1'b0);
        check(rx_empty == 1'b1, "R7", "dropped word absent", int'(rx_empty), 1);

        // R6: single holding entry
        cfg_fifo_en = 0;
        ovr_cnt = 0;
        push_tx(9'h0C3);
        check(tx_full == 1'b1, "R6", "tx_full after one word, single", int'(tx_full), 1);
        push_tx(9'h03C);
        wait_clks(4 * 11 * bc);
        check(ovr_cnt == 1, "R6", "single entry overrun", ovr_cnt, 1);
        expect_word("R6", 9'h0C3, 1'b0, 1'b0);
        check(rx_empty == 1'b1, "R6", "single entry empty", int'(rx_empty), 1);
        cfg_fifo_en = 1;

        // R8: address-wake filtering, node 0x5A
        cfg_nine = 1; cfg_addr_wake = 1; cfg_node = 8'h5A;
        ovr_cnt = 0;
        push_tx(9'h011); push_tx(9'h133); push_tx(9'h055); push_tx(9'h15A);
        push_tx(9'h022); push_tx(9'h1A0); push_tx(9'h044);
        wait_clks(9 * 12 * bc);
        expect_word("R8", 9'h15A, 1'b0, 1'b0);
        expect_word("R8", 9'h022, 1'b0, 1'b0);
        check(rx_empty == 1'b1, "R8", "filtered words absent", int'(rx_empty), 1);
        cfg_addr_wake = 0; cfg_nine = 0;

        // external receive: R3 R4 R5
        cfg_loop = 0; cfg_div = 16'd1; cfg_par_en = 1; cfg_par_odd = 0;
        drive_frame(9'h03C, 1'b0, 1'b1);
        expect_word("R3", 9'h03C, 1'b0, 1'b0);
        drive_frame(9'h0C3, 1'b1, 1'b1);
        expect_word("R3", 9'h0C3, 1'b1, 1'b0);
        cfg_par_en = 0;
        drive_frame(9'h055, 1'b0, 1'b0);
        expect_word("R5", 9'h055, 1'b0, 1'b1);
        check(rx_empty == 1'b1, "R4", "no frame from low stop tail", int'(rx_empty), 1);
        rxd = 1'b0; wait_clks(8); rxd = 1'b1;
        wait_clks(3 * bit_clks());
        check(rx_empty == 1'b1, "R4", "glitch ignored", int'(rx_empty), 1);
        // R9: rxd ignored in loopback
        cfg_loop = 1;
        rxd = 1'b0; wait_clks(3 * bit_clks()); rxd = 1'b1;
        wait_clks(2 * bit_clks());
        check(rx_empty == 1'b1, "R9", "rxd ignored", int'(rx_empty), 1);

        finish_run();
    end

    function automatic logic w_bit(logic [8:0] d, int i);
        return d[i];
    endfunction
endmodule